// File: doc/BRIEF.md
# Single-Cycle Word Processor Core

This block is a 32-bit processor that finishes one instruction in every clock cycle. It supports eight operations: a word load, a word store, a branch taken when two registers are equal, and the register-to-register operations add, subtract, bitwise and, bitwise or, and signed set-less-than. Each cycle it fetches from a read-only instruction store addressed by the program counter, reads two registers, drives one ALU, touches the data store at most once, and commits both the register result and the next program counter on the rising edge.

Both stores are arrays inside the block. Their contents come from two packed parameters: the instruction image is a constant ROM, and the data image is copied into the data store on every synchronous reset. The only ports are the clock, the reset, and a debug view. That view shows the program counter and gives a third read port into the register file, selected by the caller. No data streams in or out, so the core has no valid/ready handshake and no back-pressure. Every pin is a plain level signal.

The ALU function is chosen in two steps. The main decoder reduces the opcode to a 2-bit class: add, subtract, or use the function field. The ALU-control stage combines that class with the function field. Branch targets are computed on a dedicated adder so that the ALU stays free for the equality test.

Top module: `onecycle_cpu`

## Requirements
- R1: Unless a taken branch overrides it, the program counter advances by 4 on each rising clock edge while reset is low. An opcode other than the branch opcode 0x04 always advances it by 4.
- R2: For the branch opcode 0x04, if the registers selected by bits [25:21] and [20:16] are equal, the next program counter is PC+4 plus the sign-extended bits [15:0] shifted left by two. Otherwise it is PC+4.
- R3: For opcode 0x00, the function field bits [5:0] selects the operation: 0x20 add, 0x22 subtract, 0x24 and, 0x25 or, 0x2A signed set-less-than (result 1 or 0). The result is written to the register in bits [15:11].
- R4: For the load opcode 0x23, the byte address is the register in bits [25:21] plus the sign-extended bits [15:0]. The data word at that address is written to the register in bits [20:16].
- R5: For the store opcode 0x2B, the register in bits [20:16] is written to the data word at the same kind of effective address, and no register is written.
- R6: The branch opcode writes neither a register nor the data store.
- R7: Register 0 always reads as zero, and writes to it are discarded.
- R8: While reset is high on a rising edge, the program counter becomes 0, all registers become 0, and the data store is reloaded from its initial image.
- R9: The debug read port returns, in the same cycle, the current value of the register selected by the debug select input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| dbg_sel | input | 5 | Register index for the debug read port |
| dbg_pc | output | 32 | Current program counter (byte address) |
| dbg_rdata | output | 32 | Value of the register selected by dbg_sel |

## Verification
The bench builds the core with a 32-word instruction image and a 16-word data store. This keeps the program, the store offsets and the negative load offset within a few dozen bytes. At that size the bench can run one program that uses every opcode and function code. In that program, one branch is not taken, one branch skips two instructions, one signed compare would give the opposite result if it were unsigned, a write targets register 0, and a final self-loop holds the program counter steady. The bench then checks the program counter after each step, reads back the architectural registers, and applies a reset in the middle of a run.

// File: rtl/onecycle_pkg.sv
package onecycle_pkg;

  localparam logic [5:0] OPC_ALU   = 6'h00;
  localparam logic [5:0] OPC_LOAD  = 6'h23;
  localparam logic [5:0] OPC_STORE = 6'h2B;
  localparam logic [5:0] OPC_BREQ  = 6'h04;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  // Operation class handed from the main decoder to ALU control
  typedef enum logic [1:0] {
    CLS_ADD   = 2'b00,
    CLS_SUB   = 2'b01,
    CLS_FIELD = 2'b10,
    CLS_NONE  = 2'b11
  } op_class_e;

  typedef enum logic [2:0] {
    FU_ADD,
    FU_SUB,
    FU_AND,
    FU_OR,
    FU_SLT
  } fu_op_e;

  typedef struct packed {
    logic      dst_is_rd;  // write-back index from bits [15:11] instead of [20:16]
    logic      b_is_imm;   // ALU second operand is the sign-extended immediate
    logic      wb_from_dm; // write-back value comes from the data store
    logic      rf_write;
    logic      dm_write;
    logic      cond_branch;
    op_class_e cls;
  } ctl_t;

endpackage

// File: rtl/oc_ctrl.sv
module oc_ctrl
  import onecycle_pkg::*;
(
  input  logic [5:0] opcode,
  output ctl_t       ctl
);

  always_comb begin
    ctl = '{dst_is_rd: 1'b0, b_is_imm: 1'b0, wb_from_dm: 1'b0,
            rf_write: 1'b0, dm_write: 1'b0, cond_branch: 1'b0,
            cls: CLS_NONE};
    unique case (opcode)
      OPC_ALU: begin
        ctl.dst_is_rd = 1'b1;
        ctl.rf_write  = 1'b1;
        ctl.cls       = CLS_FIELD;
      end
      OPC_LOAD: begin
        ctl.b_is_imm   = 1'b1;
        ctl.wb_from_dm = 1'b1;
        ctl.rf_write   = 1'b1;
        ctl.cls        = CLS_ADD;
      end
      OPC_STORE: begin
        ctl.b_is_imm = 1'b1;
        ctl.dm_write = 1'b1;
        ctl.cls      = CLS_ADD;
      end
      OPC_BREQ: begin
        ctl.cond_branch = 1'b1;
        ctl.cls         = CLS_SUB;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/oc_alu.sv
module oc_alu
  import onecycle_pkg::*;
#(
  parameter int W = 32
) (
  input  op_class_e    cls,
  input  logic [5:0]   funct,
  input  logic [4:0]   shamt,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y,
  output logic         zero,
  output logic         op_ok
);

  fu_op_e fu;

  // Second decode level: class plus function field
  always_comb begin
    fu    = FU_ADD;
    op_ok = 1'b1;
    unique case (cls)
      CLS_ADD: fu = FU_ADD;
      CLS_SUB: fu = FU_SUB;
      CLS_FIELD: begin
        op_ok = (shamt == 5'd0);
        unique case (funct)
          FN_ADD:  fu = FU_ADD;
          FN_SUB:  fu = FU_SUB;
          FN_AND:  fu = FU_AND;
          FN_OR:   fu = FU_OR;
          FN_SLT:  fu = FU_SLT;
          default: op_ok = 1'b0;
        endcase
      end
      default: op_ok = 1'b0;
    endcase
  end

  logic [W-1:0] diff;
  assign diff = a - b;

  always_comb begin
    unique case (fu)
      FU_ADD:  y = a + b;
      FU_SUB:  y = diff;
      FU_AND:  y = a & b;
      FU_OR:   y = a | b;
      FU_SLT:  y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = '0;
    endcase
  end

  assign zero = (y == '0);

endmodule

// File: rtl/oc_regfile.sv
module oc_regfile #(
  parameter int W  = 32,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic [AW-1:0] ra_a,
  input  logic [AW-1:0] ra_b,
  input  logic [AW-1:0] ra_c,
  output logic [W-1:0]  rd_a,
  output logic [W-1:0]  rd_b,
  output logic [W-1:0]  rd_c
);

  localparam int N = 1 << AW;

  // Entry 0 has no storage; it is hard-wired to zero
  logic [W-1:0] regs [1:N-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 1; i < N; i++) regs[i] <= '0;
    end else if (we && (wa != '0)) begin
      regs[wa] <= wd;
    end
  end

  logic [AW-1:0] ra   [3];
  logic [W-1:0]  rdat [3];

  assign ra[0] = ra_a;
  assign ra[1] = ra_b;
  assign ra[2] = ra_c;

  for (genvar p = 0; p < 3; p++) begin : g_rport
    assign rdat[p] = (ra[p] == '0) ? '0 : regs[ra[p]];
  end

  assign rd_a = rdat[0];
  assign rd_b = rdat[1];
  assign rd_c = rdat[2];

endmodule

// File: rtl/oc_dmem.sv
module oc_dmem #(
  parameter int                     W     = 32,
  parameter int                     WORDS = 16,
  parameter logic [WORDS*W-1:0]     INIT  = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata
);

  localparam int AB = $clog2(WORDS);

  logic [W-1:0]  cells [WORDS];
  logic          hit;
  logic [AB-1:0] idx;

  // Word-aligned and inside the array; anything else reads zero and is not written
  assign hit = (addr[1:0] == 2'b00) && (addr[W-1:AB+2] == '0);
  assign idx = addr[AB+1:2];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < WORDS; i++) cells[i] <= INIT[i*W +: W];
    end else if (we && hit) begin
      cells[idx] <= wdata;
    end
  end

  assign rdata = hit ? cells[idx] : '0;

endmodule

// File: rtl/onecycle_cpu.sv
module onecycle_cpu
  import onecycle_pkg::*;
#(
  parameter int                        IMEM_WORDS = 64,
  parameter int                        DMEM_WORDS = 64,
  parameter logic [IMEM_WORDS*32-1:0]  IMEM_INIT  = '0,
  parameter logic [DMEM_WORDS*32-1:0]  DMEM_INIT  = '0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [4:0]  dbg_sel,
  output logic [31:0] dbg_pc,
  output logic [31:0] dbg_rdata
);

  localparam int W   = 32;
  localparam int IAB = $clog2(IMEM_WORDS);

  // ---------------- fetch ----------------
  logic [W-1:0]   pc_q, pc_nxt, pc_inc, br_off, br_tgt;
  logic           fetch_hit;
  logic [IAB-1:0] fetch_idx;
  logic [W-1:0]   instr;

  assign fetch_hit = (pc_q[1:0] == 2'b00) && (pc_q[W-1:IAB+2] == '0);
  assign fetch_idx = pc_q[IAB+1:2];
  // An all-zero word decodes as an invalid register operation: a no-op
  assign instr     = fetch_hit ? IMEM_INIT[fetch_idx*W +: W] : '0;

  // ---------------- decode ----------------
  logic [5:0]   f_op, f_fn;
  logic [4:0]   f_rs, f_rt, f_rd, f_sh;
  logic [15:0]  f_imm;
  ctl_t         ctl;

  assign f_op  = instr[31:26];
  assign f_rs  = instr[25:21];
  assign f_rt  = instr[20:16];
  assign f_rd  = instr[15:11];
  assign f_sh  = instr[10:6];
  assign f_fn  = instr[5:0];
  assign f_imm = instr[15:0];

  oc_ctrl u_ctrl (
    .opcode (f_op),
    .ctl    (ctl)
  );

  // ---------------- register read ----------------
  logic [W-1:0] rs_val, rt_val, wb_val;
  logic [4:0]   wb_idx;
  logic         rf_we;

  oc_regfile #(.W(W), .AW(5)) u_rf (
    .clk  (clk),
    .rst  (rst),
    .we   (rf_we),
    .wa   (wb_idx),
    .wd   (wb_val),
    .ra_a (f_rs),
    .ra_b (f_rt),
    .ra_c (dbg_sel),
    .rd_a (rs_val),
    .rd_b (rt_val),
    .rd_c (dbg_rdata)
  );

  // ---------------- execute ----------------
  logic [W-1:0] imm_sx, alu_b, alu_y;
  logic         alu_zero, alu_ok;

  assign imm_sx = {{(W-16){f_imm[15]}}, f_imm};
  assign alu_b  = ctl.b_is_imm ? imm_sx : rt_val;

  oc_alu #(.W(W)) u_alu (
    .cls   (ctl.cls),
    .funct (f_fn),
    .shamt (f_sh),
    .a     (rs_val),
    .b     (alu_b),
    .y     (alu_y),
    .zero  (alu_zero),
    .op_ok (alu_ok)
  );

  // ---------------- data store ----------------
  logic         dm_we;
  logic [W-1:0] dm_rdata;

  assign dm_we = ctl.dm_write;

  oc_dmem #(.W(W), .WORDS(DMEM_WORDS), .INIT(DMEM_INIT)) u_dm (
    .clk   (clk),
    .rst   (rst),
    .we    (dm_we),
    .addr  (alu_y),
    .wdata (rt_val),
    .rdata (dm_rdata)
  );

  // ---------------- write-back ----------------
  assign wb_idx = ctl.dst_is_rd ? f_rd : f_rt;
  assign wb_val = ctl.wb_from_dm ? dm_rdata : alu_y;
  assign rf_we  = ctl.rf_write & alu_ok;

  // ---------------- next PC ----------------
  // Offset scaled to bytes by a fixed two-place left shift, summed on its own adder
  assign br_off = {{(W-18){f_imm[15]}}, f_imm, 2'b00};
  assign pc_inc = pc_q + 32'd4;
  assign br_tgt = pc_inc + br_off;
  assign pc_nxt = (ctl.cond_branch && alu_zero) ? br_tgt : pc_inc;

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_nxt;
  end

  assign dbg_pc = pc_q;

endmodule

// File: rtl/oc_checks.sv
module oc_checks (
  input logic        clk,
  input logic        rst,
  input logic [31:0] pc,
  input logic [31:0] instr,
  input logic        reg_we,
  input logic        mem_we,
  input logic [31:0] rs_val,
  input logic [31:0] rt_val
);

  logic [5:0] op;
  assign op = instr[31:26];

  // R1
  a_r1_pc_step: assert property (@(posedge clk) disable iff (rst)
    (op != 6'h04) |=> (pc == $past(pc) + 32'd4));

  // R2
  a_r2_taken: assert property (@(posedge clk) disable iff (rst)
    (op == 6'h04 && rs_val == rt_val) |=>
      (pc == $past(pc) + 32'd4 + {{14{$past(instr[15])}}, $past(instr[15:0]), 2'b00}));

  // R2
  a_r2_not_taken: assert property (@(posedge clk) disable iff (rst)
    (op == 6'h04 && rs_val != rt_val) |=> (pc == $past(pc) + 32'd4));

  // R5
  a_r5_store_no_reg: assert property (@(posedge clk) disable iff (rst)
    (op == 6'h2B) |-> !reg_we);

  // R5
  a_r5_store_only: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (op == 6'h2B));

  // R6
  a_r6_branch_quiet: assert property (@(posedge clk) disable iff (rst)
    (op == 6'h04) |-> (!reg_we && !mem_we));

  // R7
  a_r7_zero_reg: assert property (@(posedge clk) disable iff (rst)
    (instr[25:21] == 5'd0) |-> (rs_val == 32'd0));

  // R8
  a_r8_reset_pc: assert property (@(posedge clk)
    rst |=> (pc == 32'd0));

endmodule

bind onecycle_cpu oc_checks u_checks (
  .clk    (clk),
  .rst    (rst),
  .pc     (pc_q),
  .instr  (instr),
  .reg_we (rf_we),
  .mem_we (dm_we),
  .rs_val (rs_val),
  .rt_val (rt_val)
);

// File: tb/onecycle_cpu_bench.sv
module onecycle_cpu_bench;

  localparam int CLK_P = 10;
  localparam int IMW   = 32;
  localparam int DMW   = 16;

  function automatic logic [31:0] enc_r(input int rd, input int rs, input int rt,
                                        input logic [5:0] fn);
    logic [4:0] d, s, t;
    d = rd[4:0]; s = rs[4:0]; t = rt[4:0];
    return {6'h00, s, t, d, 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs,
                                        input int rt, input int imm);
    logic [4:0]  s, t;
    logic [15:0] v;
    s = rs[4:0]; t = rt[4:0]; v = imm[15:0];
    return {op, s, t, v};
  endfunction

  function automatic logic [IMW*32-1:0] build_prog();
    logic [IMW*32-1:0] p;
    p = '0;
    p[ 0*32 +: 32] = enc_i(6'h23, 0, 1, 0);        // 0  load r1 <- 5
    p[ 1*32 +: 32] = enc_i(6'h23, 0, 2, 4);        // 4  load r2 <- 6
    p[ 2*32 +: 32] = enc_i(6'h23, 0, 3, 8);        // 8  load r3 <- -16
    p[ 3*32 +: 32] = enc_r(4, 1, 2, 6'h20);        // 12 add
    p[ 4*32 +: 32] = enc_r(5, 1, 2, 6'h22);        // 16 sub
    p[ 5*32 +: 32] = enc_r(6, 1, 2, 6'h24);        // 20 and
    p[ 6*32 +: 32] = enc_r(7, 1, 2, 6'h25);        // 24 or
    p[ 7*32 +: 32] = enc_r(8, 1, 2, 6'h2A);        // 28 slt 5<6
    p[ 8*32 +: 32] = enc_r(9, 2, 1, 6'h2A);        // 32 slt 6<5
    p[ 9*32 +: 32] = enc_r(10, 3, 1, 6'h2A);       // 36 slt -16<5
    p[10*32 +: 32] = enc_r(0, 1, 2, 6'h20);        // 40 write to r0
    p[11*32 +: 32] = enc_i(6'h2B, 0, 4, 12);       // 44 store r4 -> word 3
    p[12*32 +: 32] = enc_i(6'h23, 0, 11, 12);      // 48 load r11
    p[13*32 +: 32] = enc_i(6'h04, 1, 2, 5);        // 52 branch not taken
    p[14*32 +: 32] = enc_i(6'h04, 8, 10, 2);       // 56 branch taken -> 68
    p[15*32 +: 32] = enc_r(12, 1, 1, 6'h20);       // 60 skipped
    p[16*32 +: 32] = enc_r(12, 2, 2, 6'h20);       // 64 skipped
    p[17*32 +: 32] = enc_i(6'h23, 11, 13, -3);     // 68 load r13, negative offset
    p[18*32 +: 32] = enc_i(6'h2B, 0, 5, 16);       // 72 store r5 -> word 4
    p[19*32 +: 32] = enc_i(6'h23, 0, 14, 16);      // 76 load r14
    p[20*32 +: 32] = enc_i(6'h04, 0, 0, -1);       // 80 self loop
    return p;
  endfunction

  function automatic logic [DMW*32-1:0] build_data();
    logic [DMW*32-1:0] d;
    d = '0;
    d[0*32 +: 32] = 32'd5;
    d[1*32 +: 32] = 32'd6;
    d[2*32 +: 32] = 32'hFFFF_FFF0;
    d[3*32 +: 32] = 32'h0BAD_F00D;
    d[4*32 +: 32] = 32'h1234_5678;
    return d;
  endfunction

  localparam logic [IMW*32-1:0] PROG  = build_prog();
  localparam logic [DMW*32-1:0] DINIT = build_data();

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  dbg_sel = 5'd0;
  logic [31:0] dbg_pc, dbg_rdata;

  always #(CLK_P/2) clk = ~clk;

  onecycle_cpu #(
    .IMEM_WORDS (IMW),
    .DMEM_WORDS (DMW),
    .IMEM_INIT  (PROG),
    .DMEM_INIT  (DINIT)
  ) u_onecycle_cpu (
    .clk       (clk),
    .rst       (rst),
    .dbg_sel   (dbg_sel),
    .dbg_pc    (dbg_pc),
    .dbg_rdata (dbg_rdata)
  );

  int n_vec  = 0;
  int n_miss = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_miss++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
    $finish;
  endtask

  // Scoreboard of expected program-counter values, one per cycle
  typedef struct {
    logic [31:0] pc;
    string       tag;
  } pc_item_t;

  pc_item_t sb[$];
  logic     mon_en = 1'b0;

  task automatic push_pc(input logic [31:0] pc, input string tag);
    pc_item_t it;
    it.pc = pc; it.tag = tag;
    sb.push_back(it);
  endtask

  always @(negedge clk) begin
    if (mon_en && sb.size() > 0) begin
      pc_item_t it;
      it = sb.pop_front();
      chk(it.tag, dbg_pc, it.pc);
    end
  end

  task automatic chk_reg(input int idx, input logic [31:0] exp, input string req);
    dbg_sel = idx[4:0];
    #1;
    chk(req, dbg_rdata, exp);
  endtask

  initial begin
    #(CLK_P * 20000);
    n_vec++;
    n_miss++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset state
    chk("R8 reset pc", dbg_pc, 32'd0);
    chk_reg(1, 32'd0, "R8 reset reg");

    for (int k = 1; k <= 14; k++) push_pc(32'(4 * k), "R1 step");
    push_pc(32'd68, "R2 taken branch");
    push_pc(32'd72, "R1 step");
    push_pc(32'd76, "R1 step");
    push_pc(32'd80, "R1 step");
    for (int k = 0; k < 3; k++) push_pc(32'd80, "R2 self loop");

    @(negedge clk);
    #1;
    rst    = 1'b0;
    mon_en = 1'b1;
    wait (sb.size() == 0);
    mon_en = 1'b0;
    @(negedge clk);

    chk_reg(1,  32'd5,         "R9 debug read / R4 load");
    chk_reg(2,  32'd6,         "R6 not-taken branch left rt intact");
    chk_reg(3,  32'hFFFF_FFF0, "R4 load");
    chk_reg(4,  32'd11,        "R3 add");
    chk_reg(5,  32'hFFFF_FFFF, "R3 sub");
    chk_reg(6,  32'd4,         "R3 and");
    chk_reg(7,  32'd7,         "R3 or");
    chk_reg(8,  32'd1,         "R3 slt true");
    chk_reg(9,  32'd0,         "R3 slt false");
    chk_reg(10, 32'd1,         "R3 signed slt / R6 taken branch left rt intact");
    chk_reg(0,  32'd0,         "R7 zero register");
    chk_reg(11, 32'd11,        "R5 store then load");
    chk_reg(12, 32'd0,         "R2 skipped instructions");
    chk_reg(13, 32'hFFFF_FFF0, "R4 negative offset");
    chk_reg(14, 32'hFFFF_FFFF, "R5 second store");

    // R8: reset in the middle of a run
    @(negedge clk);
    #1;
    rst = 1'b1;
    @(negedge clk);
    chk("R8 mid-run reset pc", dbg_pc, 32'd0);
    chk_reg(4, 32'd0, "R8 mid-run reset reg");
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 restart pc", dbg_pc, 32'd12);
    chk_reg(3, 32'hFFFF_FFF0, "R8 data store reloaded");

    finish_run();
  end

endmodule